// File: doc/BRIEF.md
# Bit-Serial Shift-Add Recombination Unit

This unit sits behind a compute-in-memory subarray and rebuilds full-precision dot products from ADC samples. Inputs reach the array one bit per pass, least significant bit first. Each logical weight is 8 bits wide and is held as four 2-bit cells. An 8:1 column mux shares one ADC across eight physical columns, so every cell slice of every logical column is digitised in turn. For each slice, the unit receives a signal read and a reference read. The reference read is taken with the modulating operand at zero. The unit subtracts the reference from the signal to cancel the DC offset. It then scales the difference by the slice significance and by the input-bit position, and adds the result into a signed sum for its logical column.

A job begins with a start pulse, which clears every column sum and also latches whether the input vector is two's complement or unsigned. The unit then accepts one ADC beat per valid/ready handshake. A beat carries the signal code and the reference code together. After the final beat, the column sums are offered on a valid/ready result port and held there until the result is taken.

Top module: `cim_recomb`

## Requirements
- R1: After reset, adc_ready and res_valid are 0 and res_sum is all zeros.
- R2: A start pulse while idle clears every column sum and raises adc_ready on the next cycle.
- R3: Beats arrive in a fixed order: input bit b from 0 up to 7 (outermost), then logical column c from 0 up to COLS-1, then slice k from 0 up to 3 (innermost). While no beat is offered, the unit keeps waiting with adc_ready high.
- R4: The partial value of a beat is adc_sig minus adc_ref, both taken as unsigned 8-bit codes, and it may be negative.
- R5: The partial value is shifted left by 2k+b and added into the sum of column c.
- R6: When signed_mode was 1 at start, the contribution of input bit 7 is subtracted instead of added. When signed_mode was 0, all bits add.
- R7: On the cycle after the last beat (beat 8*COLS*4), adc_ready is 0 and res_valid is 1. Each column sum is a 24-bit two's-complement field, and column 0 sits in the least significant bits.
- R8: res_valid and res_sum stay constant until res_ready is 1 at a clock edge. After that edge the unit is idle.
- R9: A start pulse while a job is running or a result is pending has no effect.
- R10: adc_valid has no effect while adc_ready is 0.
- R11: Full-scale codes on every beat give exact sums with no overflow: 5527125 for sig=255 and ref=0 in unsigned mode, -5527125 for sig=0 and ref=255, and -21675 for sig=255 and ref=0 in signed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job; clears the sums |
| signed_mode | input | 1 | Input vector is two's complement (sampled at start) |
| adc_valid | input | 1 | ADC beat offered |
| adc_ready | output | 1 | Unit accepts ADC beats |
| adc_sig | input | 8 | Signal-read ADC code |
| adc_ref | input | 8 | Reference-read ADC code |
| res_valid | output | 1 | Column sums are complete |
| res_ready | input | 1 | Consumer takes the result |
| res_sum | output | COLS*24 | Packed signed column sums, column 0 lowest |

## Verification
The assertions assume that start, adc_valid and res_ready are driven to known values whenever rst_n is high, and that the ADC source keeps to the R3 beat order. In that case no column sum can leave its 24-bit range. The stimulus meets these conditions by driving every input on the falling edge and feeding exactly 8*COLS*4 beats per job, with idle gaps between some of them. It adds deliberate start pulses and stray ADC beats only in the windows that R9 and R10 cover.

// File: rtl/cim_recomb_pkg.sv
package cim_recomb_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    function automatic int ceil_log2(input int n);
        int r;
        r = 0;
        while ((1 << r) < n) r++;
        return (r < 1) ? 1 : r;
    endfunction

endpackage

// File: rtl/recomb_seq.sv
module recomb_seq
    import cim_recomb_pkg::*;
#(
    parameter int IN_BITS = 8,
    parameter int COLS    = 2,
    parameter int SLICES  = 4,
    localparam int BIT_W  = ceil_log2(IN_BITS),
    localparam int COL_W  = ceil_log2(COLS),
    localparam int SL_W   = ceil_log2(SLICES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             signed_mode,
    input  logic             adc_valid,
    input  logic             res_ready,
    output logic             adc_ready,
    output logic             res_valid,
    output logic             fire,
    output logic             clear,
    output logic             neg_term,
    output logic [BIT_W-1:0] bit_idx,
    output logic [COL_W-1:0] col_idx,
    output logic [SL_W-1:0]  slice_idx
);

    localparam logic [BIT_W-1:0] BIT_LAST   = BIT_W'(IN_BITS - 1);
    localparam logic [COL_W-1:0] COL_LAST   = COL_W'(COLS - 1);
    localparam logic [SL_W-1:0]  SLICE_LAST = SL_W'(SLICES - 1);

    typedef struct packed {
        phase_e           phase;
        logic [BIT_W-1:0] bitn;
        logic [COL_W-1:0] col;
        logic [SL_W-1:0]  slice;
        logic             sgn;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        clear = 1'b0;
        fire  = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase = PH_RUN;
                    s_d.bitn  = '0;
                    s_d.col   = '0;
                    s_d.slice = '0;
                    s_d.sgn   = signed_mode;
                    clear     = 1'b1;
                end
            end
            PH_RUN: begin
                if (adc_valid) begin
                    fire = 1'b1;
                    if (s_q.slice == SLICE_LAST) begin
                        s_d.slice = '0;
                        if (s_q.col == COL_LAST) begin
                            s_d.col = '0;
                            if (s_q.bitn == BIT_LAST) begin
                                s_d.phase = PH_DONE;
                            end else begin
                                s_d.bitn = s_q.bitn + 1'b1;
                            end
                        end else begin
                            s_d.col = s_q.col + 1'b1;
                        end
                    end else begin
                        s_d.slice = s_q.slice + 1'b1;
                    end
                end
            end
            PH_DONE: begin
                if (res_ready) s_d.phase = PH_IDLE;
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, bitn: '0, col: '0, slice: '0, sgn: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign adc_ready = (s_q.phase == PH_RUN);
    assign res_valid = (s_q.phase == PH_DONE);
    assign neg_term  = s_q.sgn && (s_q.bitn == BIT_LAST);
    assign bit_idx   = s_q.bitn;
    assign col_idx   = s_q.col;
    assign slice_idx = s_q.slice;

    // R2
    start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_ready && !res_valid && start) |=> adc_ready);

    // R3
    run_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_ready && !adc_valid) |=> (adc_ready && $stable(slice_idx) && $stable(col_idx)));

    // R7
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(adc_ready && res_valid));

endmodule

// File: rtl/recomb_term.sv
module recomb_term
    import cim_recomb_pkg::*;
#(
    parameter int ADC_BITS   = 8,
    parameter int IN_BITS    = 8,
    parameter int SLICES     = 4,
    parameter int SLICE_BITS = 2,
    parameter int ACC_W      = 24,
    localparam int BIT_W     = ceil_log2(IN_BITS),
    localparam int SL_W      = ceil_log2(SLICES),
    localparam int SH_W      = ceil_log2(IN_BITS + SLICES * SLICE_BITS)
) (
    input  logic [ADC_BITS-1:0]    sig_code,
    input  logic [ADC_BITS-1:0]    ref_code,
    input  logic [BIT_W-1:0]       bit_idx,
    input  logic [SL_W-1:0]        slice_idx,
    input  logic                   neg_term,
    output logic signed [ACC_W-1:0] term
);

    logic signed [ADC_BITS:0]   diff;
    logic signed [ACC_W-1:0]    diff_ext;
    logic signed [ACC_W-1:0]    shifted;
    logic [SH_W-1:0]            shamt;

    always_comb begin
        diff     = $signed({1'b0, sig_code}) - $signed({1'b0, ref_code});
        diff_ext = ACC_W'(diff);
        shamt    = SH_W'(SLICE_BITS * int'(slice_idx) + int'(bit_idx));
        shifted  = diff_ext <<< shamt;
        term     = neg_term ? -shifted : shifted;
    end

endmodule

// File: rtl/recomb_acc.sv
module recomb_acc
    import cim_recomb_pkg::*;
#(
    parameter int ACC_W = 24,
    parameter int COLS  = 2,
    localparam int COL_W = ceil_log2(COLS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    fire,
    input  logic [COL_W-1:0]        col_idx,
    input  logic signed [ACC_W-1:0] term,
    output logic [COLS*ACC_W-1:0]   sums
);

    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic signed [ACC_W-1:0] acc_d, acc_q;
        logic signed [ACC_W:0]   wide;
        logic                    sel;

        always_comb begin
            sel   = fire && (col_idx == COL_W'(c));
            wide  = {acc_q[ACC_W-1], acc_q} + {term[ACC_W-1], term};
            acc_d = acc_q;
            if (clear) begin
                acc_d = '0;
            end else if (sel) begin
                acc_d = wide[ACC_W-1:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else begin
                acc_q <= acc_d;
            end
        end

        assign sums[c*ACC_W +: ACC_W] = acc_q;

        // R11
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sel |-> (wide[ACC_W] == wide[ACC_W-1]));
    end

endmodule

// File: rtl/cim_recomb.sv
module cim_recomb
    import cim_recomb_pkg::*;
#(
    parameter int IN_BITS    = 8,
    parameter int ADC_BITS   = 8,
    parameter int SLICES     = 4,
    parameter int SLICE_BITS = 2,
    parameter int ROWS       = 128,
    parameter int COLS       = 2,
    localparam int W_BITS    = SLICES * SLICE_BITS,
    localparam int ACC_W     = IN_BITS + W_BITS + ceil_log2(ROWS) + 1,
    localparam int BIT_W     = ceil_log2(IN_BITS),
    localparam int COL_W     = ceil_log2(COLS),
    localparam int SL_W      = ceil_log2(SLICES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  signed_mode,
    input  logic                  adc_valid,
    output logic                  adc_ready,
    input  logic [ADC_BITS-1:0]   adc_sig,
    input  logic [ADC_BITS-1:0]   adc_ref,
    output logic                  res_valid,
    input  logic                  res_ready,
    output logic [COLS*ACC_W-1:0] res_sum
);

    logic                    fire, clear, neg_term;
    logic [BIT_W-1:0]        bit_idx;
    logic [COL_W-1:0]        col_idx;
    logic [SL_W-1:0]         slice_idx;
    logic signed [ACC_W-1:0] term;

    recomb_seq #(
        .IN_BITS (IN_BITS),
        .COLS    (COLS),
        .SLICES  (SLICES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .signed_mode (signed_mode),
        .adc_valid   (adc_valid),
        .res_ready   (res_ready),
        .adc_ready   (adc_ready),
        .res_valid   (res_valid),
        .fire        (fire),
        .clear       (clear),
        .neg_term    (neg_term),
        .bit_idx     (bit_idx),
        .col_idx     (col_idx),
        .slice_idx   (slice_idx)
    );

    recomb_term #(
        .ADC_BITS   (ADC_BITS),
        .IN_BITS    (IN_BITS),
        .SLICES     (SLICES),
        .SLICE_BITS (SLICE_BITS),
        .ACC_W      (ACC_W)
    ) u_term (
        .sig_code  (adc_sig),
        .ref_code  (adc_ref),
        .bit_idx   (bit_idx),
        .slice_idx (slice_idx),
        .neg_term  (neg_term),
        .term      (term)
    );

    recomb_acc #(
        .ACC_W (ACC_W),
        .COLS  (COLS)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .fire    (fire),
        .col_idx (col_idx),
        .term    (term),
        .sums    (res_sum)
    );

    // R8
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_sum)));

    // R7
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(adc_valid && adc_ready));

    // R8
    take_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ready) |=> (!res_valid && !adc_ready));

    // R10
    stray_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && adc_valid) |=> $stable(res_sum));

endmodule

// File: tb/cim_recomb_test.sv
module cim_recomb_test;

    localparam int COLS  = 2;
    localparam int ACC_W = 24;
    localparam int NBEAT = 8 * COLS * 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, signed_mode = 1'b0, adc_valid = 1'b0, res_ready = 1'b0;
    logic [7:0] adc_sig = '0, adc_ref = '0;
    logic adc_ready, res_valid;
    logic [COLS*ACC_W-1:0] res_sum;

    always #2 clk = ~clk;

    cim_recomb uut (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .adc_valid(adc_valid), .adc_ready(adc_ready), .adc_sig(adc_sig),
        .adc_ref(adc_ref), .res_valid(res_valid), .res_ready(res_ready),
        .res_sum(res_sum)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint col_out(input int c);
        logic [ACC_W-1:0] f;
        f = res_sum[c*ACC_W +: ACC_W];
        return longint'($signed(f));
    endfunction

    // behavioural model: 0 idle, 1 running, 2 result pending
    int     m_phase = 0;
    int     m_beat = 0;
    bit     m_sgn = 0;
    longint m_sum[COLS];

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            chk(1'b0, "R7 watchdog", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (!rst_n) begin
            m_phase = 0;
            for (int c = 0; c < COLS; c++) m_sum[c] = 0;
        end else begin
            case (m_phase)
                0: if (start) begin
                    m_phase = 1; m_beat = 0; m_sgn = signed_mode;
                    for (int c = 0; c < COLS; c++) m_sum[c] = 0;
                end
                1: if (adc_valid) begin
                    int b, c, k;
                    longint p;
                    b = m_beat / (COLS * 4);
                    c = (m_beat / 4) % COLS;
                    k = m_beat % 4;
                    p = (longint'(adc_sig) - longint'(adc_ref)) * (longint'(1) << (2 * k + b));
                    if (m_sgn && b == 7) m_sum[c] -= p; else m_sum[c] += p;
                    m_beat++;
                    if (m_beat == NBEAT) m_phase = 2;
                end
                default: if (res_ready) m_phase = 0;
            endcase
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(adc_ready == (m_phase == 1), "R2 adc_ready", adc_ready, m_phase == 1);
            chk(res_valid == (m_phase == 2), "R7 res_valid", res_valid, m_phase == 2);
            if (m_phase == 2)
                for (int c = 0; c < COLS; c++)
                    chk(col_out(c) == m_sum[c], "R5 column sum", col_out(c), m_sum[c]);
        end
    end

    logic [7:0] sv[NBEAT];
    logic [7:0] rv[NBEAT];

    task automatic run_job(input bit sm, input bit gaps, input int poke_at);
        @(negedge clk); start = 1'b1; signed_mode = sm;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < NBEAT; i++) begin
            if (gaps && (i % 5 == 3)) begin
                adc_valid = 1'b0; adc_sig = 8'hA5; adc_ref = 8'h11;
                @(negedge clk);
            end
            adc_valid = 1'b1; adc_sig = sv[i]; adc_ref = rv[i];
            start = (i == poke_at);
            @(negedge clk);
        end
        adc_valid = 1'b0; start = 1'b0;
    endtask

    task automatic take_result();
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk(!res_valid, "R8 idle after take", res_valid, 0);
        chk(!adc_ready, "R8 idle after take", adc_ready, 0);
    endtask

    task automatic fill(input int s, input int r);
        for (int i = 0; i < NBEAT; i++) begin sv[i] = 8'(s); rv[i] = 8'(r); end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!adc_ready, "R1 reset ready", adc_ready, 0);
        chk(!res_valid, "R1 reset valid", res_valid, 0);
        chk(res_sum == '0, "R1 reset sums", col_out(0), 0);

        // R10: beats while idle are ignored
        adc_valid = 1'b1; adc_sig = 8'd200; adc_ref = 8'd1;
        repeat (3) @(negedge clk);
        adc_valid = 1'b0;
        chk(!adc_ready && res_sum == '0, "R10 idle beats", col_out(0), 0);

        // R11 full scale, unsigned
        fill(255, 0);
        run_job(1'b0, 1'b0, -1);
        chk(col_out(0) == 64'sd5527125, "R11 unsigned max col0", col_out(0), 5527125);
        chk(col_out(1) == 64'sd5527125, "R11 unsigned max col1", col_out(1), 5527125);
        take_result();

        // R11 full scale negative difference
        fill(0, 255);
        run_job(1'b0, 1'b1, -1);
        chk(col_out(0) == -64'sd5527125, "R11 unsigned min", col_out(0), -5527125);
        take_result();

        // R6 signed mode, MSB subtracted
        fill(255, 0);
        run_job(1'b1, 1'b0, -1);
        chk(col_out(1) == -64'sd21675, "R6 signed full scale", col_out(1), -21675);
        take_result();

        // R3 R4 R5: single beat at b=2 c=1 k=3 (index 23), sig 10 ref 3
        fill(50, 50);
        sv[23] = 8'd10; rv[23] = 8'd3;
        run_job(1'b0, 1'b1, -1);
        chk(col_out(1) == 64'sd1792, "R3 beat order col1", col_out(1), 1792);
        chk(col_out(0) == 0, "R3 beat order col0", col_out(0), 0);
        // R8 hold while not taken, R9 start ignored, R10 stray beats ignored
        start = 1'b1; adc_valid = 1'b1; adc_sig = 8'd255; adc_ref = 8'd0;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        adc_valid = 1'b0;
        chk(res_valid && col_out(1) == 64'sd1792, "R8 result held", col_out(1), 1792);
        chk(res_valid && col_out(0) == 0, "R10 stray beat ignored", col_out(0), 0);
        take_result();

        // R9: start pulse mid-run does not restart; R4 signed bit 7 with negative diff
        for (int i = 0; i < NBEAT; i++) begin
            sv[i] = 8'((i * 37 + 11) % 256);
            rv[i] = 8'((i * 91 + 5) % 256);
        end
        run_job(1'b1, 1'b1, 10);
        chk(res_valid, "R9 start mid-run ignored", res_valid, 1);
        take_result();

        // mixed patterns, both modes
        for (int t = 0; t < 4; t++) begin
            for (int i = 0; i < NBEAT; i++) begin
                sv[i] = 8'($urandom_range(0, 255));
                rv[i] = 8'($urandom_range(0, 255));
            end
            run_job(t[0], t[1], -1);
            repeat (2) @(negedge clk);
            take_result();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule